// File: doc/BRIEF.md
# Scan-Line Replication Controller

This block sits between a vertical timing generator and the row address logic of a display pipeline. For every output scan line it decides which source line is shown, so that a low-resolution image can fill a taller raster. Two replication ratios are offered. Double scanning shows every source line twice. Three-of-four scanning repeats one line in each group, so that three source lines fill four output lines. A repeat flag marks each output line that shows the same source line as the line before it.

A 3-bit control code selects the ratio and also the mode class it applies to, graphics or text. The code therefore has no effect when the display runs in the other class. The code and the text/graphics flag are captured only at frame start, so the ratio cannot change partway down the screen. A separate halve bit scales the programmed vertical total down by two for the timing comparators further along the pipeline.

Top module: `scan_rep_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, `src_line` is 0, `repeat_flag` is 0 and `eff_total` is 0. Replication is off until the first frame start.
- R2: At frame start the control code is decoded with `text_mode` (1 = text, 0 = graphics). Code 1 gives double scanning in graphics. Code 2 gives three-of-four scanning in graphics. Code 5 gives double scanning in text. Code 6 gives three-of-four scanning in text.
- R3: Any other code, or a code whose class does not match `text_mode`, gives 1:1 scanning. Each `line_strobe` then increments `src_line` by one and clears `repeat_flag`.
- R4: In double scanning, `src_line` advances on every second `line_strobe`. `repeat_flag` is 1 exactly on the second output line of each pair.
- R5: In three-of-four scanning, output lines 0,1,2,3 of each group show source offsets 0,1,2,2. `repeat_flag` is 1 only on the fourth line, and the next group starts at the following source line.
- R6: A `frame_start` sets `src_line`, the group phase and `repeat_flag` to zero on the next edge. It takes priority over a `line_strobe` in the same cycle.
- R7: Changes of `mode_code` or `text_mode` between frame starts have no effect on the sequence.
- R8: One cycle after any input cycle, `eff_total` equals `vert_total` shifted right by one if `halve_en` was 1 in that cycle, and `vert_total` unchanged otherwise.
- R9: In a cycle with neither `line_strobe` nor `frame_start`, `src_line` and `repeat_flag` keep their values.
- R10: `src_line` wraps from its maximum value (2^LINE_W - 1) to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 3 | Replication control code, sampled at frame start |
| text_mode | input | 1 | 1 = text mode, 0 = graphics mode |
| halve_en | input | 1 | Halve the programmed vertical total |
| line_strobe | input | 1 | Advance to the next output scan line |
| frame_start | input | 1 | Restart the line sequence |
| vert_total | input | VT_W (11) | Programmed vertical total |
| src_line | output | LINE_W (11) | Source line shown on the current output line |
| repeat_flag | output | 1 | Current output line repeats the previous source line |
| eff_total | output | VT_W (11) | Vertical total after optional halving |

## Verification
Every code value is tried with both settings of the text flag. Over several strobes this separates the double, three-of-four and 1:1 sequences, and it shows whether the class check rejects a code that belongs to the other mode class. Directed runs cover the following cases:
- a frame start arriving together with a strobe, which shows that the restart has priority;
- a code change partway down a frame, which shows that the code is captured only at frame start;
- idle cycles;
- a full counter wrap;
- odd vertical totals with halving on and off, which tests the truncating shift.

Random traffic then mixes all inputs, so that phase sequences are exercised across frame boundaries.

// File: rtl/scanrep_pkg.sv
package scanrep_pkg;

  typedef enum logic [1:0] {
    RATIO_1_1 = 2'd0,
    RATIO_2_1 = 2'd1,
    RATIO_4_3 = 2'd2
  } ratio_e;

  localparam logic [2:0] CODE_GFX_DOUBLE = 3'd1;
  localparam logic [2:0] CODE_GFX_3OF4   = 3'd2;
  localparam logic [2:0] CODE_TXT_DOUBLE = 3'd5;
  localparam logic [2:0] CODE_TXT_3OF4   = 3'd6;

  localparam int PHASE_W = 2;

  function automatic ratio_e decode_ratio(input logic [2:0] code, input logic is_text);
    ratio_e r;
    r = RATIO_1_1;
    case (code)
      CODE_GFX_DOUBLE: if (!is_text) r = RATIO_2_1;
      CODE_GFX_3OF4:   if (!is_text) r = RATIO_4_3;
      CODE_TXT_DOUBLE: if (is_text)  r = RATIO_2_1;
      CODE_TXT_3OF4:   if (is_text)  r = RATIO_4_3;
      default:         r = RATIO_1_1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scanrep_mode_latch.sv
module scanrep_mode_latch
  import scanrep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [2:0] mode_code,
  input  logic       text_mode,
  output ratio_e     ratio_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RATIO_1_1;
    end else if (frame_start) begin
      ratio_q <= decode_ratio(mode_code, text_mode);
    end
  end

  // R7: the ratio moves only on a frame start
  assert_ratio_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(ratio_q));

  // R2: a code of the wrong class never yields replication
  assert_class_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_start && (mode_code == CODE_TXT_DOUBLE || mode_code == CODE_TXT_3OF4) && !text_mode)
      |=> ratio_q == RATIO_1_1);

endmodule

// File: rtl/scanrep_seq.sv
module scanrep_seq
  import scanrep_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_strobe,
  input  ratio_e            ratio,
  output logic [LINE_W-1:0] src_line,
  output logic              repeat_flag
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nx;
  logic               adv_nx;
  logic               rep_nx;

  always_comb begin
    phase_nx = '0;
    adv_nx   = 1'b1;
    rep_nx   = 1'b0;
    case (ratio)
      RATIO_2_1: begin
        if (phase_q[0] == 1'b0) begin
          phase_nx = PHASE_W'(1);
          adv_nx   = 1'b0;
          rep_nx   = 1'b1;
        end
      end
      RATIO_4_3: begin
        phase_nx = phase_q + 1'b1;
        if (phase_q == PHASE_W'(2)) begin
          adv_nx = 1'b0;
          rep_nx = 1'b1;
        end
      end
      default: begin
        phase_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_line    <= '0;
      repeat_flag <= 1'b0;
      phase_q     <= '0;
    end else if (frame_start) begin
      src_line    <= '0;
      repeat_flag <= 1'b0;
      phase_q     <= '0;
    end else if (line_strobe) begin
      if (adv_nx) src_line <= src_line + 1'b1;
      repeat_flag <= rep_nx;
      phase_q     <= phase_nx;
    end
  end

  // R6: frame start clears the counter and the flag
  assert_frame_clear_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (src_line == '0) && !repeat_flag);

  // R9: idle cycles hold the outputs
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !line_strobe) |=> $stable(src_line) && $stable(repeat_flag));

  // R3: plain scanning steps by one and never repeats
  assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !frame_start && ratio == RATIO_1_1)
      |=> (src_line == LINE_W'($past(src_line) + 1'b1)) && !repeat_flag);

  // R5: a repeated line is never followed by another repeat
  assert_single_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !frame_start && repeat_flag) |=> !repeat_flag);

  // R4: repeats occur only while a replicating ratio is latched
  assert_repeat_needs_ratio_R4: assert property (@(posedge clk) disable iff (rst)
    repeat_flag |-> ratio != RATIO_1_1);

endmodule

// File: rtl/scanrep_vscale.sv
module scanrep_vscale #(
  parameter int VT_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halve_en,
  input  logic [VT_W-1:0] vert_total,
  output logic [VT_W-1:0] eff_total
);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_total <= '0;
    end else if (halve_en) begin
      eff_total <= vert_total >> 1;
    end else begin
      eff_total <= vert_total;
    end
  end

  // R8: halved totals never exceed half the programmed value
  assert_halve_bound_R8: assert property (@(posedge clk) disable iff (rst)
    halve_en |=> ({1'b0, eff_total} << 1) <= {1'b0, $past(vert_total)});

endmodule

// File: rtl/scan_rep_ctrl.sv
module scan_rep_ctrl
  import scanrep_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int VT_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_code,
  input  logic              text_mode,
  input  logic              halve_en,
  input  logic              line_strobe,
  input  logic              frame_start,
  input  logic [VT_W-1:0]   vert_total,
  output logic [LINE_W-1:0] src_line,
  output logic              repeat_flag,
  output logic [VT_W-1:0]   eff_total
);

  ratio_e ratio_q;

  scanrep_mode_latch u_mode (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .mode_code   (mode_code),
    .text_mode   (text_mode),
    .ratio_q     (ratio_q)
  );

  scanrep_seq #(.LINE_W(LINE_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_strobe (line_strobe),
    .ratio       (ratio_q),
    .src_line    (src_line),
    .repeat_flag (repeat_flag)
  );

  scanrep_vscale #(.VT_W(VT_W)) u_vscale (
    .clk        (clk),
    .rst        (rst),
    .halve_en   (halve_en),
    .vert_total (vert_total),
    .eff_total  (eff_total)
  );

endmodule

// File: tb/scan_rep_ctrl_bench.sv
`timescale 1ns/1ps
module scan_rep_ctrl_bench;

  localparam int LINE_W = 11;
  localparam int VT_W   = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        mode_code = '0;
  logic              text_mode = 1'b0;
  logic              halve_en = 1'b0;
  logic              line_strobe = 1'b0;
  logic              frame_start = 1'b0;
  logic [VT_W-1:0]   vert_total = '0;
  logic [LINE_W-1:0] src_line;
  logic              repeat_flag;
  logic [VT_W-1:0]   eff_total;

  int n_checks = 0;
  int n_fails  = 0;

  // model state: ratio 0 = 1:1, 1 = 2:1, 2 = 4:3
  int                m_ratio = 0;
  int                m_phase = 0;
  logic [LINE_W-1:0] m_src = '0;
  logic              m_rep = 1'b0;
  logic [VT_W-1:0]   m_eff = '0;

  always #10 clk = ~clk;

  scan_rep_ctrl #(.LINE_W(LINE_W), .VT_W(VT_W)) u_scan_rep_ctrl (
    .clk, .rst, .mode_code, .text_mode, .halve_en, .line_strobe,
    .frame_start, .vert_total, .src_line, .repeat_flag, .eff_total
  );

  function automatic int exp_ratio(input logic [2:0] code, input logic txt);
    if (code == 3'd1 && !txt) return 1;
    if (code == 3'd2 && !txt) return 2;
    if (code == 3'd5 && txt)  return 1;
    if (code == 3'd6 && txt)  return 2;
    return 0;
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (src_line !== m_src || repeat_flag !== m_rep || eff_total !== m_eff) begin
      n_fails++;
      $display("FAIL %s: got src=%0d rep=%0b eff=%0d, expected src=%0d rep=%0b eff=%0d",
               tag, src_line, repeat_flag, eff_total, m_src, m_rep, m_eff);
    end
  endtask

  task automatic step(input logic fs, input logic st, input logic [2:0] code,
                      input logic txt, input logic hv, input logic [VT_W-1:0] vt,
                      input string tag);
    string t;
    frame_start = fs; line_strobe = st; mode_code = code;
    text_mode = txt; halve_en = hv; vert_total = vt;
    @(posedge clk);
    m_eff = hv ? (vt >> 1) : vt;
    if (fs) begin
      m_ratio = exp_ratio(code, txt);
      m_phase = 0; m_src = '0; m_rep = 1'b0;
    end else if (st) begin
      case (m_ratio)
        1: begin
          if (m_phase == 0) begin m_phase = 1; m_rep = 1'b1; end
          else begin m_phase = 0; m_rep = 1'b0; m_src = m_src + 1'b1; end
        end
        2: begin
          if (m_phase == 2) begin m_phase = 3; m_rep = 1'b1; end
          else begin m_phase = (m_phase + 1) % 4; m_rep = 1'b0; m_src = m_src + 1'b1; end
        end
        default: begin m_phase = 0; m_rep = 1'b0; m_src = m_src + 1'b1; end
      endcase
    end
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!st && !fs) t = "R9";
    else if (m_ratio == 1) t = "R4";
    else if (m_ratio == 2) t = "R5";
    else t = "R3";
    compare(t);
  endtask

  initial begin
    #4_000_000;
    n_fails++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5eed_0001);
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare("R1");

    // R2: every code with both class settings
    for (int c = 0; c < 8; c++) begin
      for (int x = 0; x < 2; x++) begin
        step(1'b1, 1'b0, 3'(c), x[0], 1'b0, 11'd525, "R2");
        for (int k = 0; k < 9; k++)
          step(1'b0, 1'b1, 3'(c), x[0], 1'b0, 11'd525, "R2");
      end
    end

    // R4 and R5 explicit sequences
    step(1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 11'd400, "R4");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 11'd400, "R4");
    step(1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 11'd400, "R5");
    for (int k = 0; k < 9; k++) step(1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 11'd400, "R5");

    // R6: frame start with strobe together
    step(1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 11'd400, "R6");
    step(1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 11'd400, "R6");
    step(1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 11'd400, "R6");

    // R7: code changes mid-frame are ignored
    step(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 11'd400, "R7");
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k % 8), k[0], 1'b0, 11'd400, "R7");

    // R9: idle
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 11'd400, "R9");

    // R8: halving with odd and even totals
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 11'd525, "R8");
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 11'd2047, "R8");
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 11'd2047, "R8");
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 11'd1, "R8");

    // R10: full wrap in 1:1
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 11'd0, "R10");
    for (int k = 0; k < 2049; k++) step(1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 11'd0, "R10");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic fs, st, tx, hv;
      logic [2:0] cd;
      logic [VT_W-1:0] vt;
      fs = (($urandom % 40) == 0);
      st = $urandom % 2;
      cd = 3'($urandom);
      tx = $urandom % 2;
      hv = $urandom % 2;
      vt = VT_W'($urandom);
      step(fs, st, cd, tx, hv, vt, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule